// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block lives in the first decode stage of an in-order integer core that has two integer pipes and five stages (prefetch, first decode, second decode with address generation, execute, writeback). In each cycle it looks at the two oldest decoded instructions, called slot 0 (older) and slot 1 (younger). It decides whether both can go down the two pipes together or whether only slot 0 may leave. If it refuses a pair, the surrounding decode logic moves slot 1 up to slot 0 for the next cycle. The block takes no part in that move.

Each slot arrives as a set of decoded fields: a valid bit, a 4-bit class code, one destination register with its enable, two source registers each with its own enable, and a displacement flag and an immediate flag. The decision is registered, so it appears one clock after the fields are presented. It is given as two mutually exclusive issue strobes and a 3-bit code that explains a refusal.

Top module: `dual_issue_pair_check`

## Requirements
- R1: While reset (rstN low) is asserted, issueBoth, issueFirstOnly and refuseReason are all 0.
- R2: The decision for the slot fields sampled at one rising edge appears on the outputs after the next rising edge (one cycle of latency). If slot 0 is not valid, no issue strobe is raised and refuseReason is 0.
- R3: If slot 0 is valid and slot 1 is not, issueFirstOnly is 1 and refuseReason is 0 (no refusal).
- R4: Class codes 0 to 9 are simple: register move, register-register ALU, shift, increment, decrement, pop, effective-address compute, near jump, near call and near conditional jump. When both slots are valid and simple, no rule below applies, and there is no dependence, issueBoth is 1 and refuseReason is 0.
- R5: If either valid slot has a class code from 10 to 15 (microcoded), the pair is refused with refuseReason 1.
- R6: If either slot has both its displacement flag and its immediate flag set, the pair is refused with refuseReason 2. A displacement alone or an immediate alone does not block pairing.
- R7: If an enabled source of slot 1 names the enabled destination of slot 0 (read after write), the pair is refused with refuseReason 3.
- R8: If both slots have an enabled destination and the two destinations are the same register (write after write), the pair is refused with refuseReason 4.
- R9: If the destination of slot 1 equals a source of slot 0 (write after read), pairing is not prevented.
- R10: When several refusal causes hold at once, the lowest nonzero code wins: 1 before 2, 2 before 3, 3 before 4.
- R11: issueBoth and issueFirstOnly are never high together, and a nonzero refuseReason is shown only together with issueFirstOnly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slot0Valid | input | 1 | Slot 0 holds an instruction |
| slot0Class | input | 4 | Slot 0 class code |
| slot0Dst | input | 3 | Slot 0 destination register |
| slot0DstEn | input | 1 | Slot 0 writes its destination |
| slot0SrcA | input | 3 | Slot 0 first source register |
| slot0SrcAEn | input | 1 | Slot 0 reads its first source |
| slot0SrcB | input | 3 | Slot 0 second source register |
| slot0SrcBEn | input | 1 | Slot 0 reads its second source |
| slot0Disp | input | 1 | Slot 0 carries a displacement |
| slot0Imm | input | 1 | Slot 0 carries an immediate |
| slot1Valid | input | 1 | Slot 1 holds an instruction |
| slot1Class | input | 4 | Slot 1 class code |
| slot1Dst | input | 3 | Slot 1 destination register |
| slot1DstEn | input | 1 | Slot 1 writes its destination |
| slot1SrcA | input | 3 | Slot 1 first source register |
| slot1SrcAEn | input | 1 | Slot 1 reads its first source |
| slot1SrcB | input | 3 | Slot 1 second source register |
| slot1SrcBEn | input | 1 | Slot 1 reads its second source |
| slot1Disp | input | 1 | Slot 1 carries a displacement |
| slot1Imm | input | 1 | Slot 1 carries an immediate |
| issueBoth | output | 1 | Both slots issue this cycle |
| issueFirstOnly | output | 1 | Only slot 0 issues |
| refuseReason | output | 3 | 0 none, 1 not simple, 2 displacement and immediate, 3 read after write, 4 write after write |

## Verification
The refusal causes can all be true in the same cycle. A microcoded class, a combined displacement and immediate, a read-after-write and a write-after-write can be present together, and only the priority order decides which code is reported. Directed vectors stack these causes two, three and four at a time. A long run of pseudo-random vectors over a small register range then produces many natural collisions. Every cycle, the registered outputs are compared with a behavioural model that tests the rules in priority order on the fields that were applied one cycle earlier.

// File: rtl/dip_pkg.sv
package dip_pkg;
  localparam int REG_W = 3;
  localparam int CLS_W = 4;
  localparam int NUM_SRC = 2;
  localparam int SIMPLE_COUNT = 10;
  localparam int REASON_W = 3;

  typedef enum logic [REASON_W-1:0] {
    RSN_NONE     = 3'd0,
    RSN_COMPLEX  = 3'd1,
    RSN_DISP_IMM = 3'd2,
    RSN_RAW      = 3'd3,
    RSN_WAW      = 3'd4
  } reason_e;

  typedef struct packed {
    logic                              valid;
    logic [CLS_W-1:0]                  cls;
    logic [REG_W-1:0]                  dst;
    logic                              dstEn;
    logic [NUM_SRC-1:0][REG_W-1:0]     src;
    logic [NUM_SRC-1:0]                srcEn;
    logic                              hasDisp;
    logic                              hasImm;
  } slot_t;

  typedef struct packed {
    logic s0Valid;
    logic s1Valid;
    logic s0Simple;
    logic s1Simple;
    logic anyDispImm;
    logic raw;
    logic waw;
  } hazard_t;

  typedef struct packed {
    logic    issueBoth;
    logic    issueFirst;
    reason_e reason;
  } decision_t;
endpackage

// File: rtl/dip_hazard_dp.sv
module dip_hazard_dp
  import dip_pkg::*;
(
  input  slot_t   older,
  input  slot_t   younger,
  output hazard_t flags
);
  logic [NUM_SRC-1:0] rawHit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_raw
    assign rawHit[i] = younger.srcEn[i] && older.dstEn && (younger.src[i] == older.dst);
  end

  function automatic logic isSimple(input logic [CLS_W-1:0] c);
    return (int'(c) < SIMPLE_COUNT);
  endfunction

  always_comb begin
    flags.s0Valid    = older.valid;
    flags.s1Valid    = younger.valid;
    flags.s0Simple   = isSimple(older.cls);
    flags.s1Simple   = isSimple(younger.cls);
    flags.anyDispImm = (older.hasDisp && older.hasImm) || (younger.hasDisp && younger.hasImm);
    flags.raw        = |rawHit;
    flags.waw        = older.dstEn && younger.dstEn && (older.dst == younger.dst);
  end
endmodule

// File: rtl/dip_issue_ctrl.sv
module dip_issue_ctrl
  import dip_pkg::*;
(
  input  hazard_t   flags,
  output decision_t dec
);
  always_comb begin
    dec.issueBoth  = 1'b0;
    dec.issueFirst = 1'b0;
    dec.reason     = RSN_NONE;
    if (flags.s0Valid) begin
      dec.issueFirst = 1'b1;
      if (flags.s1Valid) begin
        if (!(flags.s0Simple && flags.s1Simple)) dec.reason = RSN_COMPLEX;
        else if (flags.anyDispImm)               dec.reason = RSN_DISP_IMM;
        else if (flags.raw)                      dec.reason = RSN_RAW;
        else if (flags.waw)                      dec.reason = RSN_WAW;
        else begin
          dec.issueBoth  = 1'b1;
          dec.issueFirst = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check
  import dip_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                slot0Valid,
  input  logic [CLS_W-1:0]    slot0Class,
  input  logic [REG_W-1:0]    slot0Dst,
  input  logic                slot0DstEn,
  input  logic [REG_W-1:0]    slot0SrcA,
  input  logic                slot0SrcAEn,
  input  logic [REG_W-1:0]    slot0SrcB,
  input  logic                slot0SrcBEn,
  input  logic                slot0Disp,
  input  logic                slot0Imm,
  input  logic                slot1Valid,
  input  logic [CLS_W-1:0]    slot1Class,
  input  logic [REG_W-1:0]    slot1Dst,
  input  logic                slot1DstEn,
  input  logic [REG_W-1:0]    slot1SrcA,
  input  logic                slot1SrcAEn,
  input  logic [REG_W-1:0]    slot1SrcB,
  input  logic                slot1SrcBEn,
  input  logic                slot1Disp,
  input  logic                slot1Imm,
  output logic                issueBoth,
  output logic                issueFirstOnly,
  output logic [REASON_W-1:0] refuseReason
);
  slot_t     olderSlot, youngerSlot;
  hazard_t   hazFlags;
  decision_t decNext, decQ;

  always_comb begin
    olderSlot.valid   = slot0Valid;
    olderSlot.cls     = slot0Class;
    olderSlot.dst     = slot0Dst;
    olderSlot.dstEn   = slot0DstEn;
    olderSlot.src     = {slot0SrcB, slot0SrcA};
    olderSlot.srcEn   = {slot0SrcBEn, slot0SrcAEn};
    olderSlot.hasDisp = slot0Disp;
    olderSlot.hasImm  = slot0Imm;

    youngerSlot.valid   = slot1Valid;
    youngerSlot.cls     = slot1Class;
    youngerSlot.dst     = slot1Dst;
    youngerSlot.dstEn   = slot1DstEn;
    youngerSlot.src     = {slot1SrcB, slot1SrcA};
    youngerSlot.srcEn   = {slot1SrcBEn, slot1SrcAEn};
    youngerSlot.hasDisp = slot1Disp;
    youngerSlot.hasImm  = slot1Imm;
  end

  dip_hazard_dp u_dp (
    .older   (olderSlot),
    .younger (youngerSlot),
    .flags   (hazFlags)
  );

  dip_issue_ctrl u_ctrl (
    .flags (hazFlags),
    .dec   (decNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decQ <= '0;
    end else begin
      decQ <= decNext;
    end
  end

  assign issueBoth      = decQ.issueBoth;
  assign issueFirstOnly = decQ.issueFirst;
  assign refuseReason   = decQ.reason;
endmodule

// File: rtl/dual_issue_pair_check_sva.sv
module dual_issue_pair_check_sva
  import dip_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                slot0Valid,
  input logic [CLS_W-1:0]    slot0Class,
  input logic                slot1Valid,
  input logic [CLS_W-1:0]    slot1Class,
  input logic                issueBoth,
  input logic                issueFirstOnly,
  input logic [REASON_W-1:0] refuseReason
);
  // R1: outputs are quiet during reset
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_quiet: assert (!issueBoth && !issueFirstOnly && refuseReason == '0);
    end
  end

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(issueBoth && issueFirstOnly));

  a_r11_reason_only_on_refusal: assert property (@(posedge clk) disable iff (!rstN)
    (refuseReason != '0) |-> issueFirstOnly);

  a_r2_idle_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    !slot0Valid |=> (!issueBoth && !issueFirstOnly && refuseReason == '0));

  a_r3_lone_first: assert property (@(posedge clk) disable iff (!rstN)
    (slot0Valid && !slot1Valid) |=> (issueFirstOnly && refuseReason == '0));

  a_r5_complex_refused: assert property (@(posedge clk) disable iff (!rstN)
    (slot0Valid && slot1Valid && (int'(slot0Class) >= SIMPLE_COUNT || int'(slot1Class) >= SIMPLE_COUNT))
      |=> (issueFirstOnly && refuseReason == 3'd1));
endmodule

bind dual_issue_pair_check dual_issue_pair_check_sva u_sva (
  .clk            (clk),
  .rstN           (rstN),
  .slot0Valid     (slot0Valid),
  .slot0Class     (slot0Class),
  .slot1Valid     (slot1Valid),
  .slot1Class     (slot1Class),
  .issueBoth      (issueBoth),
  .issueFirstOnly (issueFirstOnly),
  .refuseReason   (refuseReason)
);

// File: tb/dual_issue_pair_check_tb.sv
`timescale 1ns/1ps
module dual_issue_pair_check_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic       s0V, s1V;
  logic [3:0] s0C, s1C;
  logic [2:0] s0D, s1D, s0A, s1A, s0B, s1B;
  logic       s0DE, s1DE, s0AE, s1AE, s0BE, s1BE, s0Di, s1Di, s0Im, s1Im;
  logic       issueBoth, issueFirstOnly;
  logic [2:0] refuseReason;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  logic       expBoth, expFirst;
  logic [2:0] expReason;
  string      expTag;

  dual_issue_pair_check u_dut (
    .clk(clk), .rstN(rstN),
    .slot0Valid(s0V), .slot0Class(s0C), .slot0Dst(s0D), .slot0DstEn(s0DE),
    .slot0SrcA(s0A), .slot0SrcAEn(s0AE), .slot0SrcB(s0B), .slot0SrcBEn(s0BE),
    .slot0Disp(s0Di), .slot0Imm(s0Im),
    .slot1Valid(s1V), .slot1Class(s1C), .slot1Dst(s1D), .slot1DstEn(s1DE),
    .slot1SrcA(s1A), .slot1SrcAEn(s1AE), .slot1SrcB(s1B), .slot1SrcBEn(s1BE),
    .slot1Disp(s1Di), .slot1Imm(s1Im),
    .issueBoth(issueBoth), .issueFirstOnly(issueFirstOnly), .refuseReason(refuseReason)
  );

  // Behavioural reference: evaluate rules in priority order on the applied fields.
  task automatic modelEval();
    int srcs[2];
    bit ens[2];
    bit raw = 0;
    expBoth = 0; expFirst = 0; expReason = 0;
    srcs[0] = s1A; srcs[1] = s1B; ens[0] = s1AE; ens[1] = s1BE;
    foreach (srcs[k]) if (ens[k] && s0DE && srcs[k] == s0D) raw = 1;
    if (!s0V) expTag = "R2";
    else if (!s1V) begin expFirst = 1; expTag = "R3"; end
    else if (s0C > 9 || s1C > 9) begin expFirst = 1; expReason = 1; expTag = "R5"; end
    else if ((s0Di && s0Im) || (s1Di && s1Im)) begin expFirst = 1; expReason = 2; expTag = "R6"; end
    else if (raw) begin expFirst = 1; expReason = 3; expTag = "R7"; end
    else if (s0DE && s1DE && s0D == s1D) begin expFirst = 1; expReason = 4; expTag = "R8"; end
    else begin expBoth = 1; expTag = "R4"; end
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (issueBoth !== expBoth || issueFirstOnly !== expFirst || refuseReason !== expReason) begin
      fails++;
      $display("FAIL %s/%s: got both=%0b first=%0b reason=%0d, expected both=%0b first=%0b reason=%0d",
               tag, expTag, issueBoth, issueFirstOnly, refuseReason, expBoth, expFirst, expReason);
    end
  endtask

  // Apply the current fields (set at a negedge), then check one cycle later (R2 latency).
  task automatic step(input string tag);
    modelEval();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic clearSlots();
    s0V = 0; s0C = 0; s0D = 0; s0DE = 0; s0A = 0; s0AE = 0; s0B = 0; s0BE = 0; s0Di = 0; s0Im = 0;
    s1V = 0; s1C = 0; s1D = 0; s1DE = 0; s1A = 0; s1AE = 0; s1B = 0; s1BE = 0; s1Di = 0; s1Im = 0;
  endtask

  // Independent two-instruction baseline: r1 = r2 op r3 ; r4 = r5 op r6
  task automatic cleanPair();
    clearSlots();
    s0V = 1; s0C = 4'd1; s0D = 3'd1; s0DE = 1; s0A = 3'd2; s0AE = 1; s0B = 3'd3; s0BE = 1;
    s1V = 1; s1C = 4'd2; s1D = 3'd4; s1DE = 1; s1A = 3'd5; s1AE = 1; s1B = 3'd6; s1BE = 1;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    clearSlots();
    s0V = 1; s1V = 1;
    repeat (3) @(negedge clk);
    // R1: outputs zero during reset despite valid inputs
    expBoth = 0; expFirst = 0; expReason = 0; expTag = "R1";
    compare("R1");
    rstN = 1;

    clearSlots();                           step("R2");
    s0V = 1;                                step("R3");
    cleanPair();                            step("R4");
    cleanPair(); s0C = 4'd9; s1C = 4'd0;    step("R4");
    cleanPair(); s0C = 4'd10;               step("R5");
    cleanPair(); s1C = 4'd15;               step("R5");
    cleanPair(); s0Di = 1; s0Im = 1;        step("R6");
    cleanPair(); s1Di = 1; s1Im = 1;        step("R6");
    cleanPair(); s0Di = 1; s1Im = 1;        step("R6");
    cleanPair(); s1A = 3'd1;                step("R7");
    cleanPair(); s1B = 3'd1;                step("R7");
    cleanPair(); s1B = 3'd1; s1BE = 0;      step("R7");
    cleanPair(); s1D = 3'd1;                step("R8");
    cleanPair(); s1D = 3'd1; s1DE = 0;      step("R8");
    cleanPair(); s1D = 3'd2;                step("R9");
    cleanPair(); s1D = 3'd3; s1A = 3'd2;    step("R9");
    cleanPair(); s1C = 4'd12; s0Di = 1; s0Im = 1; s1A = 3'd1; s1D = 3'd1; step("R10");
    cleanPair(); s1Di = 1; s1Im = 1; s1A = 3'd1; s1D = 3'd1;              step("R10");
    cleanPair(); s1B = 3'd1; s1D = 3'd1;                                  step("R10");
    cleanPair(); s0V = 0; s1C = 4'd11;      step("R2");
    cleanPair(); s1V = 0; s0C = 4'd13;      step("R3");

    for (int n = 0; n < 2000; n++) begin
      s0V = ($urandom_range(0, 7) != 0); s1V = ($urandom_range(0, 7) != 0);
      s0C = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(0, 9));
      s1C = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(0, 9));
      s0D = 3'($urandom_range(0, 3)); s1D = 3'($urandom_range(0, 3));
      s0A = 3'($urandom_range(0, 3)); s1A = 3'($urandom_range(0, 3));
      s0B = 3'($urandom_range(0, 3)); s1B = 3'($urandom_range(0, 3));
      s0DE = 1'($urandom); s1DE = 1'($urandom);
      s0AE = 1'($urandom); s1AE = 1'($urandom);
      s0BE = 1'($urandom); s1BE = 1'($urandom);
      s0Di = 1'($urandom); s1Di = 1'($urandom);
      s0Im = ($urandom_range(0, 2) == 0); s1Im = ($urandom_range(0, 2) == 0);
      step("R11");
      // R11: strobes exclusive, reason only with a refusal
      if ((issueBoth && issueFirstOnly) || (refuseReason != 0 && !issueFirstOnly)) begin
        fails++;
        $display("FAIL R11: got both=%0b first=%0b reason=%0d, expected exclusive strobes",
                 issueBoth, issueFirstOnly, refuseReason);
      end
    end
    finishRun();
  end
endmodule